// File: doc/BRIEF.md
# Streaming Elementwise Product Engine

This engine walks two operand memories in lockstep and writes the product of each pair of elements into a result memory. A one-cycle `start` pulse, given while the engine is idle, begins one pass over `N_ELEM` elements. Both operand memories receive the same read address in the same cycle. Their data comes back one cycle later.

The loop runs with a new element entering every cycle. Each element passes through three steps: a read issue, a multiply when the read data returns, and a store. While one element is being multiplied or stored, later elements are already being read. Every stage carries its own valid flag and element index, so each store goes to the index of the element that produced the product. When the last product has been stored and the pipeline is empty, `done` pulses for one cycle.

Because the engine is idle again in the cycle where `done` is high, a new pass can start in that cycle. A `start` that arrives while a pass is issuing or draining has no effect.

Top module: `vec_mul_engine`

## Requirements
- R1: After a synchronous active-low reset, `wr_en` and `done` are 0 and both read addresses are 0.
- R2: When `start` is sampled high while idle, both read addresses show 0 in the following cycle and then rise by one each cycle up to N_ELEM-1. Both addresses are always equal.
- R3: Each stored word is the unsigned 32-bit product of the two 16-bit operands read at the same index: `wr_data = x[i] * y[i]`.
- R4: The store of element i is visible two cycles after read address i was visible, with `wr_addr = i`.
- R5: A pass produces exactly N_ELEM stores. They occur in consecutive cycles with ascending addresses 0..N_ELEM-1, and each `wr_en` pulse covers a single element.
- R6: `done` is high for exactly one cycle, in the cycle after the store of element N_ELEM-1. That is N_ELEM+3 cycles after the cycle in which `start` was sampled.
- R7: A `start` sampled during issue or drain is ignored. The running pass keeps its addresses, data, store count and single `done`.
- R8: A `start` sampled in the same cycle as `done` begins a new pass, with read address 0 visible in the next cycle.
- R9: Operands at the extremes of the range are multiplied without truncation. For example, 0xFFFF times 0xFFFF stores 0xFFFE0001, and any operand times 0 stores 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass when idle |
| rd_addr_x | output | 6 | Read address to the first operand memory |
| rd_addr_y | output | 6 | Read address to the second operand memory |
| x_data | input | 16 | First operand read data, one cycle after its address |
| y_data | input | 16 | Second operand read data, one cycle after its address |
| wr_addr | output | 6 | Result memory write address |
| wr_data | output | 32 | Product to store |
| wr_en | output | 1 | Single-cycle write strobe per element |
| done | output | 1 | One-cycle pulse after the final store |

## Verification
Four kinds of operand pattern are used:

- A ramp, where x = i and y = i+1. A skewed address or an off-by-one stage pairing gives a product that does not match.
- Random operands from a fixed seed. These expose dropped or mixed-up bits in the multiply.
- Extreme values: all-ones against all-ones, and all-ones against zero. These show whether the product width is wide enough.
- A pass with `start` pulsed during issue and again during drain, followed by a pass chained from the `done` cycle. This shows whether the busy guard and the restart timing are correct.

// File: rtl/vm_pkg.sv
// Shared types for the elementwise product engine.
// Assumes nothing beyond IEEE 1800-2017 enums.
package vm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } vm_state_e;
endpackage

// File: rtl/vm_issue.sv
// Issue controller: accepts start when idle, steps the element index once
// per cycle, then waits for the pipeline to drain.
// Assumes `drained` is high for one cycle when the final element is stored.
module vm_issue #(
    parameter int N_ELEM = 64,
    parameter int AW     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          drained,
    output logic          issue_valid,
    output logic [AW-1:0] issue_idx
);
    import vm_pkg::*;

    localparam logic [AW-1:0] LAST_IDX = AW'(N_ELEM - 1);

    vm_state_e state;

    // Sequencing of idle, issue and drain, plus the index counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            issue_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_ISSUE;
                        issue_idx <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (issue_idx == LAST_IDX) begin
                        state <= ST_DRAIN;
                    end else begin
                        issue_idx <= issue_idx + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (drained) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // An index is issued in every cycle spent in the issue state.
    always_comb issue_valid = (state == ST_ISSUE);
endmodule

// File: rtl/vm_stage.sv
// One pipeline stage: a valid flag and a payload that advance together.
// Assumes the payload is only meaningful while the valid flag is set.
module vm_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    // Move valid and payload forward every cycle; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_data;
        end
    end
endmodule

// File: rtl/vec_mul_engine.sv
// Elementwise product engine: p[i] = x[i] * y[i] with one element entering per cycle.
// The pipeline runs read issue -> data return and multiply -> store.
// Assumes both operand memories return data exactly one cycle after the address.
module vec_mul_engine #(
    parameter int N_ELEM = 64,
    parameter int OPW    = 16,
    parameter int AW     = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [AW-1:0]     rd_addr_x,
    output logic [AW-1:0]     rd_addr_y,
    input  logic [OPW-1:0]    x_data,
    input  logic [OPW-1:0]    y_data,
    output logic [AW-1:0]     wr_addr,
    output logic [2*OPW-1:0]  wr_data,
    output logic              wr_en,
    output logic              done
);
    localparam int PW = 2 * OPW;
    localparam logic [AW-1:0] LAST_IDX = AW'(N_ELEM - 1);

    logic          issue_valid;
    logic [AW-1:0] issue_idx;
    logic          ld_valid;
    logic [AW-1:0] ld_idx;
    logic          st_valid;
    logic [AW+PW-1:0] st_payload;
    logic [PW-1:0] product;
    logic          last_store;

    vm_issue #(.N_ELEM(N_ELEM), .AW(AW)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .drained     (last_store),
        .issue_valid (issue_valid),
        .issue_idx   (issue_idx)
    );

    // Both operand memories share one address.
    always_comb begin
        rd_addr_x = issue_idx;
        rd_addr_y = issue_idx;
    end

    // Load-return stage: the index travels alongside the outstanding reads.
    vm_stage #(.W(AW)) u_ld_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (issue_valid),
        .in_data   (issue_idx),
        .out_valid (ld_valid),
        .out_data  (ld_idx)
    );

    // Full-width unsigned multiply of the returned operands.
    always_comb product = PW'(x_data) * PW'(y_data);

    // Multiply stage: registers the product with its element index.
    vm_stage #(.W(AW + PW)) u_mul_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ld_valid),
        .in_data   ({ld_idx, product}),
        .out_valid (st_valid),
        .out_data  (st_payload)
    );

    // Store port is driven straight from the multiply stage.
    always_comb begin
        wr_en      = st_valid;
        wr_addr    = st_payload[AW+PW-1:PW];
        wr_data    = st_payload[PW-1:0];
        last_store = st_valid && (st_payload[AW+PW-1:PW] == LAST_IDX);
    end

    // Completion pulse in the cycle after the final store.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last_store;
    end
endmodule

// File: rtl/vm_checks.sv
// Protocol checks for vec_mul_engine, attached by bind.
// Assumes the same parameter values as the bound instance.
module vm_checks #(
    parameter int N_ELEM = 64,
    parameter int OPW    = 16,
    parameter int AW     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    rd_addr_x,
    input logic [AW-1:0]    rd_addr_y,
    input logic [OPW-1:0]   x_data,
    input logic [OPW-1:0]   y_data,
    input logic [AW-1:0]    wr_addr,
    input logic [2*OPW-1:0] wr_data,
    input logic             wr_en,
    input logic             done
);
    localparam int PW = 2 * OPW;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!wr_en && !done && rd_addr_x == '0));

    p_addr_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_x == rd_addr_y);

    p_product_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_data == $past(PW'(x_data) * PW'(y_data)));

    p_store_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_addr == $past(rd_addr_x, 2));

    p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + 1'b1);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && $past(wr_addr) == AW'(N_ELEM - 1) && !wr_en));
endmodule

bind vec_mul_engine vm_checks #(.N_ELEM(N_ELEM), .OPW(OPW), .AW(AW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_x (rd_addr_x),
    .rd_addr_y (rd_addr_y),
    .x_data    (x_data),
    .y_data    (y_data),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .done      (done)
);

// File: tb/vec_mul_engine_tb.sv
module vec_mul_engine_tb;
    localparam int N   = 64;
    localparam int AW  = 6;
    localparam int OPW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0]  rd_addr_x, rd_addr_y, wr_addr;
    logic [OPW-1:0] x_data = '0, y_data = '0;
    logic [31:0]    wr_data;
    logic           wr_en, done;

    logic [OPW-1:0] xm [N];
    logic [OPW-1:0] ym [N];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vec_mul_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_addr_x(rd_addr_x), .rd_addr_y(rd_addr_y),
        .x_data(x_data), .y_data(y_data),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .done(done)
    );

    // Operand memories with one-cycle read latency
    always @(posedge clk) begin
        x_data <= xm[rd_addr_x];
        y_data <= ym[rd_addr_y];
    end

    function automatic logic [31:0] mul_ref(input logic [15:0] a, input logic [15:0] b);
        return 32'(a) * 32'(b);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One pass. Called just after a negedge; start is either driven here or already set by a chain.
    task automatic run_pass(input bit drive_start, input bit chain, input int ign_a, input int ign_b,
                            input string dtag);
        int nwr = 0;
        int ndone = 0;
        int last = chain ? N + 3 : N + 5;
        if (drive_start) start = 1'b1;
        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            start = (k == ign_a) || (k == ign_b) || (chain && k == N + 3);
            if (k <= N) begin
                chk(rd_addr_x == AW'(k - 1) && rd_addr_y == AW'(k - 1), "R2", 32'(rd_addr_x), 32'(k - 1));
                if (k == 1 && !drive_start)
                    chk(rd_addr_x == '0, "R8", 32'(rd_addr_x), 32'd0);
            end
            chk(wr_en == (k >= 3 && k <= N + 2), "R5", 32'(wr_en), 32'(k >= 3 && k <= N + 2));
            if (wr_en) nwr++;
            if (k >= 3 && k <= N + 2) begin
                chk(wr_addr == AW'(k - 3), "R4", 32'(wr_addr), 32'(k - 3));
                chk(wr_data == mul_ref(xm[k - 3], ym[k - 3]), dtag, wr_data, mul_ref(xm[k - 3], ym[k - 3]));
            end
            chk(done == (k == N + 3), "R6", 32'(done), 32'(k == N + 3));
            if (done) ndone++;
        end
        if (ign_a > 0) begin
            chk(nwr == N, "R7", 32'(nwr), 32'(N));
            chk(ndone == 1, "R7", 32'(ndone), 32'd1);
        end else begin
            chk(nwr == N, "R5", 32'(nwr), 32'(N));
        end
    endtask

    initial begin
        void'($urandom(32'd20240917));
        for (int i = 0; i < N; i++) begin
            xm[i] = OPW'(i);
            ym[i] = OPW'(i + 1);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!wr_en, "R1", 32'(wr_en), 32'd0);
        chk(!done, "R1", 32'(done), 32'd0);
        chk(rd_addr_x == '0, "R1", 32'(rd_addr_x), 32'd0);

        // Directed ramp
        run_pass(1'b1, 1'b0, 0, 0, "R3");

        // Random operands
        for (int i = 0; i < N; i++) begin
            xm[i] = OPW'($urandom);
            ym[i] = OPW'($urandom);
        end
        run_pass(1'b1, 1'b0, 0, 0, "R3");

        // Extremes, R9
        for (int i = 0; i < N; i++) begin
            xm[i] = 16'hFFFF;
            ym[i] = (i % 2 == 0) ? 16'hFFFF : 16'h0000;
        end
        run_pass(1'b1, 1'b0, 0, 0, "R9");

        // Start pulses during issue and drain (R7), then chained restart
        for (int i = 0; i < N; i++) begin
            xm[i] = OPW'($urandom);
            ym[i] = OPW'($urandom);
        end
        run_pass(1'b1, 1'b1, 10, N + 1, "R3");
        for (int i = 0; i < N; i++) begin
            xm[i] = OPW'($urandom);
            ym[i] = OPW'(N - i);
        end
        // R8: pass begun from the done cycle
        run_pass(1'b0, 1'b0, 0, 0, "R3");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule